// File: doc/BRIEF.md
# Pad Output Function Router

This block connects each physical pad to one of four function slots. The slot supplies the level the pad drives and the pad's output-enable. Each pad has its own 2-bit select register. Software writes it through a single-cycle write port addressed by pad index, and a combinational read port returns it. The output level and the output-enable of a pad always come from the same slot, because both are steered by the same select value.

A slot is either bidirectional or fixed-direction. A bidirectional slot, such as general-purpose I/O or a shared data bus, supplies its own output-enable, and the pad uses it as given. A fixed-direction slot has a constant output-enable set by parameter, and its own enable wire is ignored. The block also provides the pad input-enable as the inverse of the output-enable. Each pad selects exactly one slot, so two functions can never drive one pad. Any number of pads may select the same slot.

Top module: `pad_out_router`

## Requirements
- R1: While reset is asserted and after it, every select register reads 0, so every pad follows slot 0.
- R2: When a write is enabled with an address below NUM_PADS, that pad's select takes the written value at the next clock edge and reads back through rd_data. All other pads keep their selects.
- R3: pad_out[p] equals slot_out[p*4+k], where k is pad p's select. Several pads may select the same slot number at the same time, and each follows its own slot input.
- R4: When a pad selects a bidirectional slot, pad_oe[p] equals slot_oe[p*4+k]. By default slots 0 and 2 are bidirectional.
- R5: When a pad selects a fixed-direction slot, pad_oe[p] is that slot's constant and slot_oe is ignored. By default slot 1 drives 1 (output) and slot 3 drives 0 (input).
- R6: pad_ie[p] is always the inverse of pad_oe[p].
- R7: A write to an address at or above NUM_PADS changes no select, and reading such an address returns 0.
- R8: A select write affects the pad outputs only from the clock edge that stores it. Changes on slot inputs reach the pads in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Select register write strobe |
| wr_addr | input | ADDR_W | Pad index to write |
| wr_data | input | 2 | New slot select |
| rd_addr | input | ADDR_W | Pad index to read |
| rd_data | output | 2 | Select of the addressed pad, 0 if out of range |
| slot_out | input | NUM_PADS*4 | Slot output levels, bit p*4+k is slot k of pad p |
| slot_oe | input | NUM_PADS*4 | Slot output-enables, same layout |
| pad_out | output | NUM_PADS | Level driven to each pad |
| pad_oe | output | NUM_PADS | Output-enable of each pad |
| pad_ie | output | NUM_PADS | Input-enable of each pad |

## Verification
A select write and a change on the slot inputs can land in the same cycle. The slot inputs act at once, while the new select only acts after the clock edge. The bench provokes this by writing a pad's select on the same falling edge that changes the slot patterns. Before the rising edge, it expects the pad to show the old slot with the new input values. After the edge, it expects the newly selected slot, including that slot's direction rule.

// File: rtl/pad_out_router.sv
module pad_out_router #(
  parameter int NUM_PADS = 6,
  parameter logic [3:0] SLOT_BIDIR = 4'b0101,
  parameter logic [3:0] SLOT_FIXED_OE = 4'b0010,
  localparam int ADDR_W = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [1:0]              wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [1:0]              rd_data,
  input  logic [NUM_PADS*4-1:0]   slot_out,
  input  logic [NUM_PADS*4-1:0]   slot_oe,
  output logic [NUM_PADS-1:0]     pad_out,
  output logic [NUM_PADS-1:0]     pad_oe,
  output logic [NUM_PADS-1:0]     pad_ie
);
  localparam logic [ADDR_W:0] PAD_LIMIT = (ADDR_W+1)'(NUM_PADS);

  logic [NUM_PADS*2-1:0] sel_q;
  logic wr_ok, rd_ok;

  assign wr_ok = wr_en && ({1'b0, wr_addr} < PAD_LIMIT);
  assign rd_ok = {1'b0, rd_addr} < PAD_LIMIT;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      sel_q <= '0;
    else if (wr_ok)
      sel_q[wr_addr*2 +: 2] <= wr_data;

  assign rd_data = rd_ok ? sel_q[rd_addr*2 +: 2] : 2'b00;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic [1:0] s;
    logic [3:0] o, eff_oe;
    assign s      = sel_q[p*2 +: 2];
    assign o      = slot_out[p*4 +: 4];
    assign eff_oe = (slot_oe[p*4 +: 4] & SLOT_BIDIR) | (SLOT_FIXED_OE & ~SLOT_BIDIR);
    assign pad_out[p] = o[s];
    assign pad_oe[p]  = eff_oe[s];
    assign pad_ie[p]  = ~eff_oe[s];
  end
endmodule

// File: rtl/pad_out_router_chk.sv
module pad_out_router_chk #(
  parameter int NUM_PADS = 6,
  parameter logic [3:0] SLOT_BIDIR = 4'b0101,
  parameter logic [3:0] SLOT_FIXED_OE = 4'b0010,
  localparam int ADDR_W = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [1:0]            wr_data,
  input logic [NUM_PADS*2-1:0] sel_q,
  input logic [NUM_PADS*4-1:0] slot_oe,
  input logic [NUM_PADS-1:0]   pad_oe,
  input logic [NUM_PADS-1:0]   pad_ie
);
  localparam logic [ADDR_W:0] PAD_LIMIT = (ADDR_W+1)'(NUM_PADS);
  logic good_wr, bad_wr;
  assign good_wr = wr_en && ({1'b0, wr_addr} < PAD_LIMIT);
  assign bad_wr  = wr_en && !({1'b0, wr_addr} < PAD_LIMIT);

  assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |=> sel_q == '0);

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    good_wr |=> sel_q[$past(wr_addr)*2 +: 2] == $past(wr_data));

  assert_bad_addr_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> $stable(sel_q));

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_chk
    assert_bidir_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      SLOT_BIDIR[sel_q[p*2 +: 2]] |-> pad_oe[p] == slot_oe[p*4 + sel_q[p*2 +: 2]]);
    assert_fixed_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !SLOT_BIDIR[sel_q[p*2 +: 2]] |-> pad_oe[p] == SLOT_FIXED_OE[sel_q[p*2 +: 2]]);
    assert_ie_opposes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pad_ie[p] != pad_oe[p]);
  end
endmodule

bind pad_out_router pad_out_router_chk #(
  .NUM_PADS(NUM_PADS), .SLOT_BIDIR(SLOT_BIDIR), .SLOT_FIXED_OE(SLOT_FIXED_OE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .sel_q(sel_q), .slot_oe(slot_oe), .pad_oe(pad_oe), .pad_ie(pad_ie)
);

// File: tb/pad_out_router_test.sv
module pad_out_router_test;
  localparam int NP = 6;
  localparam int AW = 3;
  localparam int NV = 9;
  // {pad[3], sel[2], out[4], oe[4], exp_out, exp_oe}
  localparam logic [14:0] VEC [NV] = '{
    {3'd0, 2'd0, 4'b0001, 4'b0001, 1'b1, 1'b1},
    {3'd1, 2'd1, 4'b0010, 4'b0000, 1'b1, 1'b1},
    {3'd2, 2'd2, 4'b0000, 4'b0100, 1'b0, 1'b1},
    {3'd3, 2'd3, 4'b1000, 4'b1000, 1'b1, 1'b0},
    {3'd4, 2'd2, 4'b1011, 4'b1011, 1'b0, 1'b0},
    {3'd5, 2'd0, 4'b1110, 4'b1110, 1'b0, 1'b0},
    {3'd0, 2'd1, 4'b1101, 4'b1111, 1'b0, 1'b1},
    {3'd5, 2'd3, 4'b0111, 4'b0111, 1'b0, 1'b0},
    {3'd2, 2'd0, 4'b0001, 4'b0000, 1'b1, 1'b0}
  };

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [1:0] wr_data = '0, rd_data;
  logic [NP*4-1:0] slot_out = '0, slot_oe = '0;
  logic [NP-1:0] pad_out, pad_oe, pad_ie;
  logic [1:0] model [NP];
  int checks = 0, fails = 0;
  bit done = 0;

  always #10ns clk = ~clk;

  pad_out_router uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .slot_out(slot_out),
    .slot_oe(slot_oe), .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] o, logic [3:0] e);
    slot_out = {NP{o}};
    slot_oe  = {NP{e}};
  endtask

  task automatic write_sel(int pad, logic [1:0] v);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(pad); wr_data = v;
    @(negedge clk);
    wr_en = 0;
    if (pad < NP) model[pad] = v;
  endtask

  task automatic check_readback(string req);
    for (int p = 0; p < NP; p++) begin
      rd_addr = AW'(p);
      #1;
      check(req, rd_data, model[p]);
    end
  endtask

  initial begin
    #(20ns * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) model[p] = 2'd0;
    drive(4'b0001, 4'b0000);
    repeat (3) @(negedge clk);
    #1;
    check_readback("R1 reset select");
    check("R1 reset pads follow slot0", pad_out, {NP{1'b1}});
    check("R1 reset oe", pad_oe, 0);
    rst_n = 1;
    @(negedge clk); #1;
    check_readback("R1 after reset");

    for (int v = 0; v < NV; v++) begin
      int pad;
      pad = int'(VEC[v][14:12]);
      write_sel(pad, VEC[v][11:10]);
      drive(VEC[v][9:6], VEC[v][5:2]);
      #1;
      check("R3 pad_out", pad_out[pad], VEC[v][1]);
      check("R4/R5 pad_oe", pad_oe[pad], VEC[v][0]);
      check("R6 pad_ie", pad_ie[pad], !VEC[v][0]);
      rd_addr = AW'(pad); #1;
      check("R2 readback", rd_data, VEC[v][11:10]);
    end
    check_readback("R2 other pads untouched");

    for (int p = 0; p < NP; p++) write_sel(p, 2'd1);
    drive(4'b0010, 4'b0000);
    #1;
    check("R3 fan-out all pads high", pad_out, {NP{1'b1}});
    check("R5 fixed output slot oe", pad_oe, {NP{1'b1}});
    slot_out[3*4+1] = 1'b0; #1;
    check("R3 per-pad input", pad_out, {NP{1'b1}} & ~(NP'(1) << 3));
    drive(4'b0000, 4'b1111);
    write_sel(3, 2'd3); #1;
    check("R5 fixed input ignores slot_oe", pad_oe[3], 0);
    check("R6 input enabled", pad_ie[3], 1);

    write_sel(6, 2'd2);
    write_sel(7, 2'd3);
    check_readback("R7 invalid write ignored");
    rd_addr = 3'd6; #1;
    check("R7 invalid read zero", rd_data, 0);
    rd_addr = 3'd7; #1;
    check("R7 invalid read zero", rd_data, 0);

    @(negedge clk);
    wr_en = 1; wr_addr = 3'd1; wr_data = 2'd2;
    drive(4'b0010, 4'b0000);
    #1;
    check("R8 old select before edge out", pad_out[1], 1);
    check("R8 old select before edge oe", pad_oe[1], 1);
    @(negedge clk);
    wr_en = 0; model[1] = 2'd2;
    #1;
    check("R8 new select out", pad_out[1], 0);
    check("R8 new select bidir oe", pad_oe[1], 0);
    check("R8 new select ie", pad_ie[1], 1);
    check_readback("R8 readback");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule